// File: doc/BRIEF.md
# Multiply/Divide Unit with Busy Interlock

This block is the multiply/divide engine of a 32-bit processor core. It takes a start strobe with a two-bit operation code and two 32-bit operands. It produces a 64-bit result that is split across a HI and a LO register. The four operations are signed multiply, unsigned multiply, signed divide and unsigned divide.

Each operation loads a busy counter with its latency. Divides always take 37 cycles. A multiply takes 7, 11 or 15 cycles, picked from how many significant bits the first operand carries. The result is computed at issue and held internally. It is copied into HI/LO on the cycle the counter runs out. A HI or LO read request while the counter is nonzero raises the stall output, so the pipeline waits until the new value is in place. The stall output depends combinationally on the read request.

Top module: `muldiv_interlock`

## Requirements
- R1: After reset, HI and LO read as zero, the busy counter is zero and stall is low.
- R2: Operation code 2'b00 is a signed multiply and 2'b01 an unsigned multiply; bits [63:32] of the 64-bit product go to HI and bits [31:0] to LO.
- R3: An unsigned multiply takes 7 + 4*(2 - n/11) cycles, where n is the count of leading zeros of (A | 1) and the division truncates.
- R4: A signed multiply takes the same formula, with n counted on ((A XOR (A arithmetically shifted right by 21)) | 1).
- R5: Operation codes 2'b10 (signed divide) and 2'b11 (unsigned divide) take 37 cycles.
- R6: A divide by a nonzero divisor puts the truncated quotient in LO and the remainder in HI; a signed remainder takes the sign of the dividend.
- R7: A divide by zero puts the dividend in HI; LO becomes 0xFFFFFFFF for an unsigned divide or a non-negative dividend, and 0x00000001 otherwise.
- R8: A signed divide of 0x80000000 by 0xFFFFFFFF gives LO = 0x80000000 and HI = 0.
- R9: Stall is high exactly when a HI or LO read is requested and the busy counter is nonzero; with no read request, stall stays low.
- R10: HI and LO keep their previous values until the counter of the latest operation expires, then show its result.
- R11: A new operation issued while busy discards the pending result and restarts the counter with the new latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Start strobe for a new operation |
| op_code | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| op_a | input | 32 | First operand (multiplicand / dividend) |
| op_b | input | 32 | Second operand (multiplier / divisor) |
| rd_hi | input | 1 | HI read request |
| rd_lo | input | 1 | LO read request |
| stall | output | 1 | Read must wait for the running operation |
| hi_data | output | 32 | HI register |
| lo_data | output | 32 | LO register |

## Verification
The bench measures the stall length with a read held. A unit that counted leading zeros on the raw operand instead of the folded one would give small negative multiplicands a 15-cycle latency instead of 7. The bench drives operands at the 11- and 22-zero thresholds, where an off-by-one in the bucket choice changes the latency by four cycles. Division by zero and the 0x80000000 / -1 overflow are driven directly, since a plain language divide there returns unknowns or a wrong sign. Back-to-back issues check that the first result never appears, and the cycle just before expiry checks that HI/LO have not been updated early.

// File: rtl/muldiv_interlock.sv
module muldiv_interlock #(
  parameter int XLEN       = 32,
  parameter int FOLD_SHIFT = 21,
  parameter int DIV_LAT    = 37,
  parameter int MUL_BASE   = 7,
  parameter int MUL_STEP   = 4,
  parameter int MUL_SPAN   = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [1:0]      op_code,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic            rd_hi,
  input  logic            rd_lo,
  output logic            stall,
  output logic [XLEN-1:0] hi_data,
  output logic [XLEN-1:0] lo_data
);
  localparam int CW = $clog2(DIV_LAT + 1);
  localparam int LZW = $clog2(XLEN + 1);
  localparam int NBUCK = (XLEN - 1) / MUL_SPAN;

  logic [CW-1:0]   busy;
  logic [XLEN-1:0] hi_q, lo_q, hi_pend, lo_pend;
  logic [XLEN-1:0] hi_new, lo_new;
  logic [CW-1:0]   lat;

  function automatic logic [LZW-1:0] lead_zeros(input logic [XLEN-1:0] v);
    lead_zeros = LZW'(XLEN);
    for (int i = 0; i < XLEN; i++)
      if (v[i]) lead_zeros = LZW'(XLEN - 1 - i);
  endfunction

  wire is_div = op_code[1];
  wire is_uns = op_code[0];

  wire [XLEN-1:0] fold  = op_a ^ XLEN'($signed(op_a) >>> FOLD_SHIFT);
  wire [XLEN-1:0] lz_in = (is_uns ? op_a : fold) | XLEN'(1);
  wire [LZW-1:0]  lz    = lead_zeros(lz_in);

  always_comb begin
    int q;
    q = int'(lz) / MUL_SPAN;
    if (q > NBUCK) q = NBUCK;
    lat = is_div ? CW'(DIV_LAT) : CW'(MUL_BASE + MUL_STEP * (NBUCK - q));
  end

  wire [2*XLEN-1:0] prod_s = $signed({{XLEN{op_a[XLEN-1]}}, op_a}) *
                             $signed({{XLEN{op_b[XLEN-1]}}, op_b});
  wire [2*XLEN-1:0] prod_u = {{XLEN{1'b0}}, op_a} * {{XLEN{1'b0}}, op_b};

  wire neg_a = !is_uns && op_a[XLEN-1];
  wire neg_b = !is_uns && op_b[XLEN-1];
  wire [XLEN-1:0] mag_a = neg_a ? -op_a : op_a;
  wire [XLEN-1:0] mag_b = neg_b ? -op_b : op_b;
  wire            b_zero = (op_b == '0);
  wire [XLEN-1:0] safe_b = b_zero ? XLEN'(1) : mag_b;
  wire [XLEN-1:0] q_mag  = mag_a / safe_b;
  wire [XLEN-1:0] r_mag  = mag_a % safe_b;

  always_comb begin
    if (!is_div) begin
      {hi_new, lo_new} = is_uns ? prod_u : prod_s;
    end else if (b_zero) begin
      hi_new = op_a;
      lo_new = neg_a ? XLEN'(1) : '1;
    end else begin
      hi_new = neg_a ? -r_mag : r_mag;
      lo_new = (neg_a ^ neg_b) ? -q_mag : q_mag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      hi_pend <= '0;
      lo_pend <= '0;
    end else if (op_valid) begin
      busy    <= lat;
      hi_pend <= hi_new;
      lo_pend <= lo_new;
    end else if (busy != '0) begin
      busy <= busy - CW'(1);
      if (busy == CW'(1)) begin
        hi_q <= hi_pend;
        lo_q <= lo_pend;
      end
    end
  end

  assign stall   = (rd_hi | rd_lo) && (busy != '0);
  assign hi_data = hi_q;
  assign lo_data = lo_q;
endmodule

module muldiv_interlock_chk #(
  parameter int CW       = 6,
  parameter int XLEN     = 32,
  parameter int DIV_LAT  = 37,
  parameter int MUL_BASE = 7,
  parameter int MUL_STEP = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_valid,
  input logic [1:0]      op_code,
  input logic            rd_hi,
  input logic            rd_lo,
  input logic            stall,
  input logic [CW-1:0]   busy,
  input logic [XLEN-1:0] hi_q,
  input logic [XLEN-1:0] lo_q
);
  // R9
  idle_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy == '0) |-> !stall);
  // R9
  no_read_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_hi || rd_lo) |-> !stall);
  // R5
  div_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code[1]) |=> (busy == CW'(DIV_LAT)));
  // R3
  mul_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_code[1]) |=> (busy == CW'(MUL_BASE) ||
      busy == CW'(MUL_BASE + MUL_STEP) || busy == CW'(MUL_BASE + 2*MUL_STEP)));
  // R11
  countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy != '0 && !op_valid) |=> (busy == $past(busy) - CW'(1)));
  // R10
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy > CW'(1) && !op_valid) |=> ($stable(hi_q) && $stable(lo_q)));
endmodule

bind muldiv_interlock muldiv_interlock_chk #(
  .CW(CW), .XLEN(XLEN), .DIV_LAT(DIV_LAT), .MUL_BASE(MUL_BASE), .MUL_STEP(MUL_STEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .rd_hi(rd_hi), .rd_lo(rd_lo), .stall(stall), .busy(busy),
  .hi_q(hi_q), .lo_q(lo_q)
);

// File: tb/tb_muldiv_interlock.sv
`timescale 1ns/1ps
module tb_muldiv_interlock;
  logic clk = 0, rst_n = 0, op_valid = 0, rd_hi = 0, rd_lo = 0;
  logic [1:0] op_code = 0;
  logic [31:0] op_a = 0, op_b = 0;
  logic stall;
  logic [31:0] hi_data, lo_data;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  muldiv_interlock dut (.*);

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int exp_lat(input logic [1:0] c, input logic [31:0] a);
    logic [31:0] v;
    int n;
    if (c[1]) return 37;
    v = c[0] ? a : (a ^ 32'($signed(a) >>> 21));
    v = v | 32'd1;
    n = 0;
    while (!v[31]) begin n++; v = v << 1; end
    return 7 + 4 * (2 - n / 11);
  endfunction

  function automatic logic [63:0] exp_res(input logic [1:0] c, input logic [31:0] a, input logic [31:0] b);
    logic signed [63:0] sp;
    logic [31:0] q, r;
    case (c)
      2'b00: begin sp = 64'($signed(a)) * 64'($signed(b)); return sp; end
      2'b01: return {32'd0, a} * {32'd0, b};
      2'b10: begin
        if (b == 0) return {a, a[31] ? 32'd1 : 32'hFFFF_FFFF};
        if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return {32'd0, 32'h8000_0000};
        q = $signed(a) / $signed(b);
        r = $signed(a) % $signed(b);
        return {r, q};
      end
      default: begin
        if (b == 0) return {a, 32'hFFFF_FFFF};
        return {a % b, a / b};
      end
    endcase
  endfunction

  task automatic run_op(input logic [1:0] c, input logic [31:0] a, input logic [31:0] b, input string tag);
    logic [63:0] prev, exp;
    int cnt, el;
    prev = {hi_data, lo_data};
    exp = exp_res(c, a, b);
    el = exp_lat(c, a);
    @(negedge clk);
    op_valid = 1; op_code = c; op_a = a; op_b = b; rd_hi = 1;
    @(negedge clk);
    op_valid = 0;
    // R10: old values still visible right after issue
    check({hi_data, lo_data} == prev, {tag, " R10 hold"}, {hi_data, lo_data}, prev);
    cnt = 0;
    while (stall && cnt < 100) begin cnt++; @(negedge clk); end
    check(cnt == el, {tag, " latency"}, 64'(cnt), 64'(el));
    check({hi_data, lo_data} == exp, {tag, " result"}, {hi_data, lo_data}, exp);
    rd_hi = 0;
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    rd_hi = 1; rd_lo = 1;
    #0;
    check(!stall, "R1 stall after reset", 64'(stall), 64'd0);
    check({hi_data, lo_data} == 64'd0, "R1 hi/lo after reset", {hi_data, lo_data}, 64'd0);
    rd_hi = 0; rd_lo = 0;

    // R2 R3 R4 thresholds
    run_op(2'b01, 32'h0000_0005, 32'h0000_0007, "R3 R2 umul small");
    run_op(2'b01, 32'h0020_0000, 32'hFFFF_FFFF, "R3 umul lz10");
    run_op(2'b01, 32'h0010_0000, 32'h1234_5678, "R3 umul lz11");
    run_op(2'b01, 32'h0000_0400, 32'h8765_4321, "R3 umul lz21");
    run_op(2'b01, 32'h0000_0200, 32'h0000_0003, "R3 umul lz22");
    run_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 R2 umul max");
    run_op(2'b00, 32'hFFFF_FFFE, 32'h0000_0003, "R4 R2 smul small neg");
    run_op(2'b00, 32'h8000_0000, 32'h8000_0000, "R4 R2 smul min");
    run_op(2'b00, 32'hFFF0_0000, 32'h7FFF_FFFF, "R4 smul mid neg");
    run_op(2'b00, 32'h0000_0100, 32'hFFFF_FFFF, "R4 smul pos small");

    // R5 R6 R7 R8
    run_op(2'b10, 32'hFFFF_FFF9, 32'h0000_0002, "R5 R6 sdiv neg/pos");
    run_op(2'b10, 32'h0000_0007, 32'hFFFF_FFFE, "R6 sdiv pos/neg");
    run_op(2'b11, 32'hFFFF_FFF9, 32'h0000_0002, "R5 R6 udiv");
    run_op(2'b10, 32'hFFFF_FFF0, 32'h0000_0000, "R7 sdiv neg by zero");
    run_op(2'b10, 32'h0000_0010, 32'h0000_0000, "R7 sdiv pos by zero");
    run_op(2'b11, 32'h8000_0001, 32'h0000_0000, "R7 udiv by zero");
    run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, "R8 sdiv overflow");

    // R9: no read, no stall while busy
    @(negedge clk);
    op_valid = 1; op_code = 2'b11; op_a = 100; op_b = 7;
    @(negedge clk);
    op_valid = 0;
    for (int i = 0; i < 5; i++) begin
      check(!stall, "R9 no read no stall", 64'(stall), 64'd0);
      @(negedge clk);
    end
    rd_lo = 1; #0;
    check(stall, "R9 lo read stalls", 64'(stall), 64'd1);
    rd_lo = 0;
    for (int i = 0; i < 40; i++) @(negedge clk);
    rd_lo = 1; #0;
    check(!stall, "R9 read after expiry", 64'(stall), 64'd0);
    check(lo_data == 32'd14 && hi_data == 32'd2, "R6 udiv 100/7", {hi_data, lo_data}, {32'd2, 32'd14});
    rd_lo = 0;

    // R11 restart
    @(negedge clk);
    op_valid = 1; op_code = 2'b10; op_a = 32'd1000; op_b = 32'd3;
    @(negedge clk);
    op_valid = 0;
    repeat (4) @(negedge clk);
    run_op(2'b01, 32'd6, 32'd9, "R11 restart");

    // random
    for (int i = 0; i < 250; i++) begin
      logic [1:0] c;
      logic [31:0] a, b;
      c = 2'($urandom);
      a = $urandom >> ($urandom % 32);
      if ($urandom % 2) a = -a;
      b = ($urandom % 8 == 0) ? 32'd0 : ($urandom >> ($urandom % 32));
      run_op(c, a, b, "R2 R3 R4 R6 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule